// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Unit

This block is the multiply-accumulate datapath that sits beside the integer pipeline of a 32-bit processor. It keeps three registers that software can see: a 32-bit accumulator, a general mask register, and an 8-bit status register. The status register holds a 4-bit mode field and three condition flags. On each cycle where `valid_i` is high, the block takes two 16-bit operands, a 32-bit data word and a 3-bit command. It then does one of three things: multiplies and adds the product to the accumulator (or subtracts it), runs a standalone multiply whose result goes back to the caller, or loads one of its registers.

The mode field is set at run time and takes effect on the next accumulate. It chooses:
- saturating or wrapping accumulation;
- signed or unsigned operands;
- integer or fractional (Q1.15) operands;
- truncation or round-to-nearest for the 16-bit readout view.

Reads are combinational from the registers. A read in the cycle after an accumulate therefore sees the new value. The flags are also always driven out in the processor's condition-code layout. Instruction decode, operand fetch and memory access belong to the surrounding pipeline.

Top module: `mac_unit`

## Requirements
- R1: After reset, the accumulator, mask and status registers read zero, and `res_valid_o` is low.
- R2: Command 0 (add-accumulate) adds the product of `op_a_i` and `op_b_i` to the accumulator at the clock edge. A read of selector 0 in the next cycle returns the new value.
- R3: Command 1 (subtract-accumulate) subtracts the product from the accumulator.
- R4: With status bit 6 set, operands are zero-extended (unsigned). With it clear, they are sign-extended.
- R5: With status bit 5 set (fractional), the product is shifted left by one bit before it is accumulated.
- R6: With status bit 7 set (saturate), an accumulate that overflows clamps the accumulator. Signed results clamp to 0x7FFFFFFF or 0x80000000. Unsigned results clamp to 0xFFFFFFFF or 0.
- R7: With status bit 7 clear, an overflowing accumulate keeps the low 32 bits of the exact result.
- R8: Every accumulate sets status bit 3 (N) to the accumulator MSB and bit 2 (Z) to whether the result is zero. Bit 1 (V) is set by an overflow and stays set until the status register is written. Bit 0 reads zero.
- R9: Command 2 (signed multiply) and command 3 (unsigned multiply) put the 32-bit product on `res_o`, with `res_valid_o` high for the one cycle after the command. These commands leave the accumulator and the flags untouched.
- R10: Command 4 loads the accumulator from `data_i`, command 5 loads the status register from `data_i[7:1]`, and command 6 loads the mask. Read selectors 0, 1 and 2 return the accumulator, the mask and the zero-extended status. A load of the accumulator does not change the flags.
- R11: `ccr_o` carries N at bit 3, Z at bit 2 and V at bit 1. Bits 4 and 0 are zero.
- R12: Read selector 3 returns, zero-extended, the accumulator's upper 16 bits. With status bit 4 clear this is a plain truncation. With bit 4 set, bit 15 is added, except that an upper half already at its maximum (0x7FFF signed, 0xFFFF unsigned) is held there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code |
| op_a_i | input | 16 | First multiplier operand |
| op_b_i | input | 16 | Second multiplier operand |
| data_i | input | 32 | Register load value |
| rd_sel_i | input | 2 | Read selector: 0 accumulator, 1 mask, 2 status, 3 rounded upper half |
| rd_data_o | output | 32 | Combinational read data |
| res_o | output | 32 | Standalone multiply result |
| res_valid_o | output | 1 | Multiply result valid |
| ccr_o | output | 5 | Flags in condition-code layout |

## Verification
The bench targets the signed and unsigned overflow boundaries.

- **Clamp direction.** It pushes the accumulator just past 0x7FFFFFFF and just below 0x80000000, then past all-ones and below zero in unsigned mode. A design that mixed up the overflow test or the clamp direction would return the wrong extreme value, or a wrapped one.
- **Sticky overflow.** It checks that V survives a later accumulate that does not overflow, and that it clears only on a status write. A non-sticky flag would drop to zero one accumulate too early.
- **Fractional alignment and rounding.** It checks the one-bit fractional shift on a 0.5 × 0.5 product. It also checks rounding at the exact half, just below the half, and at the positive maximum. An unclamped rounder would wrap 0x7FFF around to 0x8000.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [2:0] {
      CMD_MACC = 3'd0,
      CMD_MSUB = 3'd1,
      CMD_MULS = 3'd2,
      CMD_MULU = 3'd3,
      CMD_LACC = 3'd4,
      CMD_LSTS = 3'd5,
      CMD_LMSK = 3'd6,
      CMD_NONE = 3'd7
   } mac_cmd_e;

   typedef enum logic [1:0] {
      RD_ACC  = 2'd0,
      RD_MSK  = 2'd1,
      RD_STS  = 2'd2,
      RD_HALF = 2'd3
   } mac_rd_e;

   localparam int STS_W    = 8;
   localparam int B_SAT    = 7;
   localparam int B_UNS    = 6;
   localparam int B_FRAC   = 5;
   localparam int B_RND    = 4;
   localparam int B_NEG    = 3;
   localparam int B_ZERO   = 2;
   localparam int B_OVF    = 1;

   localparam int CCR_W    = 5;

endpackage

// File: rtl/mac_product.sv
module mac_product #(
   parameter int OPW  = 16,
   parameter int ACCW = 32,
   localparam int PW  = ACCW + 2
) (
   input  logic [OPW-1:0]        a_i,
   input  logic [OPW-1:0]        b_i,
   input  logic                  uns_i,
   input  logic                  frac_i,
   output logic signed [PW-1:0]  prod_o,
   output logic signed [PW-1:0]  raw_o
);
   localparam int XW = OPW + 1;
   localparam int RW = 2 * XW;

   if (ACCW < 2 * OPW) begin : g_bad_width
      $error("mac_product: accumulator narrower than full product");
   end

   logic signed [XW-1:0] ax, bx;
   logic signed [RW-1:0] p_full;
   logic signed [PW-1:0] p_ext;

   always_comb begin
      ax     = uns_i ? $signed({1'b0, a_i}) : $signed({a_i[OPW-1], a_i});
      bx     = uns_i ? $signed({1'b0, b_i}) : $signed({b_i[OPW-1], b_i});
      p_full = ax * bx;
      p_ext  = p_full;
      raw_o  = p_ext;
      prod_o = frac_i ? (p_ext <<< 1) : p_ext;
   end

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
   parameter int ACCW = 32,
   localparam int PW  = ACCW + 2,
   localparam int SW  = ACCW + 3
) (
   input  logic [ACCW-1:0]       acc_i,
   input  logic signed [PW-1:0]  prod_i,
   input  logic                  sub_i,
   input  logic                  uns_i,
   input  logic                  sat_i,
   output logic [ACCW-1:0]       res_o,
   output logic                  ovf_o
);
   localparam logic [ACCW-1:0] S_MAX = {1'b0, {(ACCW-1){1'b1}}};
   localparam logic [ACCW-1:0] S_MIN = {1'b1, {(ACCW-1){1'b0}}};
   localparam logic [ACCW-1:0] U_MAX = {ACCW{1'b1}};
   localparam logic [ACCW-1:0] U_MIN = '0;

   logic signed [SW-1:0] acc_x, prod_x, sum;
   logic                 neg;
   logic [SW-ACCW:0]     top_s;
   logic [SW-ACCW-1:0]   top_u;

   always_comb begin
      acc_x  = uns_i ? $signed({3'b000, acc_i})
                     : $signed({{3{acc_i[ACCW-1]}}, acc_i});
      prod_x = prod_i;
      sum    = sub_i ? (acc_x - prod_x) : (acc_x + prod_x);
      neg    = sum[SW-1];
      top_s  = sum[SW-1:ACCW-1];
      top_u  = sum[SW-1:ACCW];
      if (uns_i) ovf_o = (top_u != '0);
      else       ovf_o = !((top_s == '0) || (top_s == '1));
      if (sat_i && ovf_o) begin
         if (uns_i) res_o = neg ? U_MIN : U_MAX;
         else       res_o = neg ? S_MIN : S_MAX;
      end else begin
         res_o = sum[ACCW-1:0];
      end
   end

   // R6
   always_comb begin
      if (sat_i && ovf_o) begin
         sat_clamp_chk: assert (res_o == S_MAX || res_o == S_MIN ||
                                res_o == U_MAX || res_o == U_MIN);
      end
   end

endmodule

// File: rtl/mac_round.sv
module mac_round #(
   parameter int OPW       = 16,
   parameter int ACCW      = 32,
   parameter bit CLAMP_RND = 1'b1
) (
   input  logic [OPW:0]     hi_i,
   input  logic             rnd_i,
   input  logic             uns_i,
   output logic [ACCW-1:0]  half_o
);
   localparam logic [OPW-1:0] HS_MAX = {1'b0, {(OPW-1){1'b1}}};
   localparam logic [OPW-1:0] HU_MAX = {OPW{1'b1}};

   if (ACCW <= OPW) begin : g_bad_width
      $error("mac_round: accumulator must exceed the readout width");
   end

   logic [OPW-1:0] upper;
   logic           half_bit;
   logic [OPW-1:0] bumped;
   logic           at_max;

   assign upper    = hi_i[OPW:1];
   assign half_bit = hi_i[0];
   assign at_max   = uns_i ? (upper == HU_MAX) : (upper == HS_MAX);

   if (CLAMP_RND) begin : g_clamp
      assign bumped = at_max ? upper : upper + OPW'(half_bit);
   end else begin : g_wrap
      assign bumped = upper + OPW'(half_bit);
   end

   assign half_o = {{(ACCW-OPW){1'b0}}, (rnd_i ? bumped : upper)};

endmodule

// File: rtl/mac_unit.sv
module mac_unit
   import mac_pkg::*;
#(
   parameter int OPW       = 16,
   parameter int ACCW      = 32,
   parameter bit CLAMP_RND = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic [2:0]       cmd_i,
   input  logic [OPW-1:0]   op_a_i,
   input  logic [OPW-1:0]   op_b_i,
   input  logic [ACCW-1:0]  data_i,
   input  logic [1:0]       rd_sel_i,
   output logic [ACCW-1:0]  rd_data_o,
   output logic [ACCW-1:0]  res_o,
   output logic             res_valid_o,
   output logic [CCR_W-1:0] ccr_o
);
   localparam int PW = ACCW + 2;

   if (ACCW < STS_W) begin : g_bad_width
      $error("mac_unit: accumulator narrower than status register");
   end

   logic [ACCW-1:0]       acc_q, msk_q, res_q;
   logic [STS_W-1:0]      sts_q;
   logic                  rv_q;
   mac_cmd_e              cmd;
   logic                  do_acc, do_mul, mul_uns;
   logic signed [PW-1:0]  prod, raw;
   logic [ACCW-1:0]       acc_nx, half;
   logic                  ovf;

   assign cmd     = mac_cmd_e'(cmd_i);
   assign do_acc  = valid_i && (cmd == CMD_MACC || cmd == CMD_MSUB);
   assign do_mul  = valid_i && (cmd == CMD_MULS || cmd == CMD_MULU);
   assign mul_uns = do_mul ? (cmd == CMD_MULU) : sts_q[B_UNS];

   mac_product #(.OPW(OPW), .ACCW(ACCW)) u_prod (
      .a_i    (op_a_i),
      .b_i    (op_b_i),
      .uns_i  (mul_uns),
      .frac_i (sts_q[B_FRAC]),
      .prod_o (prod),
      .raw_o  (raw)
   );

   mac_accum #(.ACCW(ACCW)) u_acc (
      .acc_i  (acc_q),
      .prod_i (prod),
      .sub_i  (cmd == CMD_MSUB),
      .uns_i  (sts_q[B_UNS]),
      .sat_i  (sts_q[B_SAT]),
      .res_o  (acc_nx),
      .ovf_o  (ovf)
   );

   mac_round #(.OPW(OPW), .ACCW(ACCW), .CLAMP_RND(CLAMP_RND)) u_rnd (
      .hi_i   (acc_q[ACCW-1 -: OPW+1]),
      .rnd_i  (sts_q[B_RND]),
      .uns_i  (sts_q[B_UNS]),
      .half_o (half)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         msk_q <= '0;
         sts_q <= '0;
         res_q <= '0;
         rv_q  <= 1'b0;
      end else begin
         rv_q <= do_mul;
         if (do_mul) res_q <= raw[ACCW-1:0];
         if (do_acc) begin
            acc_q         <= acc_nx;
            sts_q[B_NEG]  <= acc_nx[ACCW-1];
            sts_q[B_ZERO] <= (acc_nx == '0);
            sts_q[B_OVF]  <= sts_q[B_OVF] | ovf;
         end else if (valid_i) begin
            case (cmd)
               CMD_LACC: acc_q <= data_i;
               CMD_LSTS: sts_q <= {data_i[STS_W-1:1], 1'b0};
               CMD_LMSK: msk_q <= data_i;
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      case (mac_rd_e'(rd_sel_i))
         RD_ACC:  rd_data_o = acc_q;
         RD_MSK:  rd_data_o = msk_q;
         RD_STS:  rd_data_o = {{(ACCW-STS_W){1'b0}}, sts_q};
         default: rd_data_o = half;
      endcase
   end

   assign res_o       = res_q;
   assign res_valid_o = rv_q;
   assign ccr_o       = {1'b0, sts_q[B_NEG], sts_q[B_ZERO], sts_q[B_OVF], 1'b0};

   // R8
   v_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[B_OVF] && !(valid_i && cmd == CMD_LSTS)) |=> sts_q[B_OVF]);

   // R8
   z_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_acc |=> (ccr_o[2] == (rd_sel_i != 2'd0 || rd_data_o == '0 ? (acc_q == '0) : 1'b0)));

   // R9
   mul_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_mul |=> (res_valid_o && acc_q == $past(acc_q)));

   // R10
   acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && cmd == CMD_LACC) |=> (acc_q == $past(data_i)));

   // R10
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(valid_i && cmd == CMD_LMSK) |=> $stable(msk_q));

endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [2:0]  cmd_i = 3'd7;
   logic [15:0] op_a_i = '0, op_b_i = '0;
   logic [31:0] data_i = '0;
   logic [1:0]  rd_sel_i = 2'd0;
   logic [31:0] rd_data_o, res_o;
   logic        res_valid_o;
   logic [4:0]  ccr_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   mac_unit dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cmd_i(cmd_i),
      .op_a_i(op_a_i), .op_b_i(op_b_i), .data_i(data_i),
      .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .res_o(res_o),
      .res_valid_o(res_valid_o), .ccr_o(ccr_o)
   );

   task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic issue(logic [2:0] c, logic [15:0] a, logic [15:0] b, logic [31:0] d);
      @(negedge clk);
      valid_i = 1'b1; cmd_i = c; op_a_i = a; op_b_i = b; data_i = d;
      @(negedge clk);
      valid_i = 1'b0; cmd_i = 3'd7;
   endtask

   task automatic rd(logic [1:0] s, output logic [31:0] v);
      rd_sel_i = s; #0.5; v = rd_data_o;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(2'd0, v); chk("R1 acc", v, 0);
      rd(2'd1, v); chk("R1 mask", v, 0);
      rd(2'd2, v); chk("R1 status", v, 0);
      chk("R1 res_valid", {31'd0, res_valid_o}, 0);
   endtask

   task automatic t_int_accum;
      logic [31:0] v;
      issue(3'd5, 0, 0, 32'h00);
      issue(3'd0, 16'd3, 16'hFFFC, 0);
      rd(2'd0, v); chk("R2 mac 3*-4", v, 32'hFFFF_FFF4);
      rd(2'd2, v); chk("R8 N set", v, 32'h08);
      issue(3'd1, 16'd3, 16'hFFFC, 0);
      rd(2'd0, v); chk("R3 msac to zero", v, 0);
      rd(2'd2, v); chk("R8 Z set", v, 32'h04);
      chk("R11 ccr zero", {27'd0, ccr_o}, 32'h04);
   endtask

   task automatic t_unsigned_frac;
      logic [31:0] v;
      issue(3'd5, 0, 0, 32'h40);
      issue(3'd4, 0, 0, 0);
      issue(3'd0, 16'hFFFF, 16'hFFFF, 0);
      rd(2'd0, v); chk("R4 unsigned product", v, 32'hFFFE_0001);
      issue(3'd5, 0, 0, 32'h00);
      issue(3'd4, 0, 0, 0);
      issue(3'd0, 16'hFFFF, 16'hFFFF, 0);
      rd(2'd0, v); chk("R4 signed product", v, 32'h1);
      issue(3'd5, 0, 0, 32'h20);
      issue(3'd4, 0, 0, 0);
      issue(3'd0, 16'h4000, 16'h4000, 0);
      rd(2'd0, v); chk("R5 frac half*half", v, 32'h2000_0000);
   endtask

   task automatic t_saturate;
      logic [31:0] v;
      issue(3'd5, 0, 0, 32'h80);
      issue(3'd4, 0, 0, 32'h7FFF_FFF0);
      issue(3'd0, 16'd1, 16'h7FFF, 0);
      rd(2'd0, v); chk("R6 signed high clamp", v, 32'h7FFF_FFFF);
      rd(2'd2, v); chk("R8 V set on overflow", v[1], 1);
      issue(3'd4, 0, 0, 32'h8000_0005);
      issue(3'd1, 16'd2, 16'd10, 0);
      rd(2'd0, v); chk("R6 signed low clamp", v, 32'h8000_0000);
      issue(3'd4, 0, 0, 32'h0000_0100);
      issue(3'd0, 16'd1, 16'd1, 0);
      rd(2'd2, v); chk("R8 V sticky", v, 32'h82);
      issue(3'd5, 0, 0, 32'hC0);
      rd(2'd2, v); chk("R8 V cleared by write", v, 32'hC0);
      issue(3'd4, 0, 0, 32'd5);
      issue(3'd1, 16'd1, 16'd10, 0);
      rd(2'd0, v); chk("R6 unsigned low clamp", v, 0);
      issue(3'd4, 0, 0, 32'hFFFF_FFF0);
      issue(3'd0, 16'd1, 16'h20, 0);
      rd(2'd0, v); chk("R6 unsigned high clamp", v, 32'hFFFF_FFFF);
   endtask

   task automatic t_wrap;
      logic [31:0] v;
      issue(3'd5, 0, 0, 32'h00);
      issue(3'd4, 0, 0, 32'h7FFF_FFF0);
      issue(3'd0, 16'd1, 16'h20, 0);
      rd(2'd0, v); chk("R7 wrap", v, 32'h8000_0010);
      chk("R11 ccr N,V", {27'd0, ccr_o}, 32'h0A);
   endtask

   task automatic t_mul_regs;
      logic [31:0] v;
      issue(3'd4, 0, 0, 32'h1234_5678);
      @(negedge clk);
      valid_i = 1'b1; cmd_i = 3'd2; op_a_i = 16'hFFFF; op_b_i = 16'd2;
      @(negedge clk);
      valid_i = 1'b0; cmd_i = 3'd7;
      chk("R9 muls valid", {31'd0, res_valid_o}, 1);
      chk("R9 muls result", res_o, 32'hFFFF_FFFE);
      @(negedge clk);
      chk("R9 valid drops", {31'd0, res_valid_o}, 0);
      issue(3'd3, 16'hFFFF, 16'd2, 0);
      chk("R9 mulu result", res_o, 32'h0001_FFFE);
      rd(2'd0, v); chk("R9 acc untouched", v, 32'h1234_5678);
      issue(3'd6, 0, 0, 32'hA5A5_5A5A);
      rd(2'd1, v); chk("R10 mask readback", v, 32'hA5A5_5A5A);
      issue(3'd5, 0, 0, 32'hFF);
      rd(2'd2, v); chk("R10 status bit0 zero", v, 32'hFE);
   endtask

   task automatic t_round;
      logic [31:0] v;
      issue(3'd5, 0, 0, 32'h20);
      issue(3'd4, 0, 0, 32'h1234_8000);
      rd(2'd3, v); chk("R12 truncate", v, 32'h1234);
      issue(3'd5, 0, 0, 32'h30);
      rd(2'd3, v); chk("R12 round half up", v, 32'h1235);
      issue(3'd4, 0, 0, 32'h1234_7FFF);
      rd(2'd3, v); chk("R12 below half", v, 32'h1234);
      issue(3'd4, 0, 0, 32'h7FFF_8000);
      rd(2'd3, v); chk("R12 clamp at max", v, 32'h7FFF);
   endtask

   initial begin
      #200000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_int_accum();
      t_unsigned_frac();
      t_saturate();
      t_wrap();
      t_mul_regs();
      t_round();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule